// File: doc/BRIEF.md
# Seconds and Ticks Timekeeper with Pulse-Aligned Loading

This block holds absolute time as two counters: a whole-seconds count and a sub-second tick count. The tick count advances on every clock and wraps at a programmable ticks-per-second limit, and each wrap adds one to the seconds count. Software programs the block by single-word writes on a settings-style bus, where each register is addressed by a word index. On a byte-addressed bus, a register's address is the block base plus four times its index.

A new time value is staged in two load registers and then committed by a write to the load-control register. The commit happens either on the very next clock edge or on the next chosen edge of an external pulse-per-second input. That input is first passed through a two-flop synchronizer, and software selects whether a rising or a falling edge counts. The current time is read back as a consistent pair. Reading the seconds takes a snapshot of the ticks from the same cycle, and the ticks read returns that snapshot.

Top module: `sectick_timekeeper`

## Requirements
- R1: Writes are decoded by word index: 0 stages the seconds load value, 1 stages the ticks load value, 2 holds flags (bit 0 picks the pulse edge), 3 is load control (bit 0: 1 loads at once, 0 arms a pulse-aligned load), and 4 holds the ticks-per-second limit.
- R2: While reset is asserted, and until the first read after it, the read data is 0. After reset, seconds and ticks both start at 0, the ticks-per-second limit takes the value of parameter DEF_TPS, and no load is pending.
- R3: With no load taking effect, ticks step up by one on each clock. On a clock where ticks are at or above the limit minus one, ticks become 0 and seconds increase by one on that same clock.
- R4: A limit of 0 behaves exactly like a limit of 1: ticks stay at 0 and seconds advance on every clock.
- R5: A write of 1 to index 3 loads the staged seconds and ticks on the clock edge that accepts the write. That write also cancels any pending load.
- R6: A write of 0 to index 3 arms a load. The armed load takes effect on the third rising clock edge after the pulse input changes to the selected level. Until then the time keeps counting.
- R7: When flags bit 0 is 1 only a rising pulse edge commits an armed load, and when it is 0 only a falling edge does. The other edge has no effect.
- R8: Each arm produces exactly one load. Pulse edges after that load do not change the time.
- R9: On the clock where a load takes effect, the loaded values replace the counter update for that cycle.
- R10: A read with rd_sel=0 returns the seconds count on rd_data one cycle later and snapshots the ticks from the same cycle. A following read with rd_sel=1 returns that snapshot.
- R11: Writes to indices 0, 1 and 2 never change the running seconds or ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Word index of the written register |
| wr_data | input | DATA_W | Write data |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 reads seconds and snapshots ticks, 1 reads the ticks snapshot |
| rd_data | output | DATA_W | Registered read data, valid the cycle after rd_en |

## Verification
The assertions check on every cycle that the counters step, wrap and load as required. They also check that a load only happens when one was requested, that an armed load clears once it has fired, and that the snapshot and seconds readback capture the values from the cycle of the read. Only the bench scenarios can show the absolute timing seen at the ports. That covers the three-edge latency from the pulse input to the load, the rejection of the non-selected edge, the effect of the limit on long runs across many limits and start ticks, and the rule that writes to the staging registers leave the running time untouched.

// File: rtl/tk_pkg.sv
package tk_pkg;

  // Word indices on the settings bus
  localparam int unsigned TK_IDX_SECS  = 0;
  localparam int unsigned TK_IDX_TICKS = 1;
  localparam int unsigned TK_IDX_FLAGS = 2;
  localparam int unsigned TK_IDX_LOAD  = 3;
  localparam int unsigned TK_IDX_TPS   = 4;

  // Pulse edge selection carried in flags bit 0
  typedef enum logic {
    TK_EDGE_FALL = 1'b0,
    TK_EDGE_RISE = 1'b1
  } tk_edge_e;

endpackage

// File: rtl/tk_rst_sync.sv
module tk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tk_pps_edge.sv
module tk_pps_edge
  import tk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pps_in,
  input  tk_edge_e edge_sel,
  output logic     pps_hit
);

  localparam int unsigned PW = SYNC_STAGES + 1;

  // Synchronizer stages followed by one history flop for edge detection
  logic [PW-1:0] pipe_q;
  logic [PW-1:0] pipe_d;
  logic          cur_lvl;
  logic          prev_lvl;

  always_comb begin
    pipe_d   = {pipe_q[PW-2:0], pps_in};
    cur_lvl  = pipe_q[SYNC_STAGES-1];
    prev_lvl = pipe_q[SYNC_STAGES];
    if (edge_sel == TK_EDGE_RISE) pps_hit = cur_lvl & ~prev_lvl;
    else                          pps_hit = ~cur_lvl & prev_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

endmodule

// File: rtl/tk_ctrl.sv
module tk_ctrl
  import tk_pkg::*;
#(
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned TICK_W  = 32,
  parameter int unsigned DEF_TPS = 100000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pps_hit,
  output logic [SEC_W-1:0]  ld_secs,
  output logic [TICK_W-1:0] ld_ticks,
  output logic [TICK_W-1:0] tps_last,
  output tk_edge_e          edge_sel,
  output logic              pending,
  output logic              apply
);

  logic              sel_secs, sel_ticks, sel_flags, sel_load, sel_tps;
  logic              imm_fire, arm_fire;
  logic [SEC_W-1:0]  ld_secs_q;
  logic [TICK_W-1:0] ld_ticks_q, tps_q;
  tk_edge_e          edge_q;
  logic              pend_q, pend_d;

  // Register decode
  always_comb begin
    sel_secs  = wr_en && (wr_idx == IDX_W'(TK_IDX_SECS));
    sel_ticks = wr_en && (wr_idx == IDX_W'(TK_IDX_TICKS));
    sel_flags = wr_en && (wr_idx == IDX_W'(TK_IDX_FLAGS));
    sel_load  = wr_en && (wr_idx == IDX_W'(TK_IDX_LOAD));
    sel_tps   = wr_en && (wr_idx == IDX_W'(TK_IDX_TPS));
    imm_fire  = sel_load &  wr_data[0];
    arm_fire  = sel_load & ~wr_data[0];
  end

  // Pending load: a load-control write overrides, a fired load clears
  always_comb begin
    pend_d = pend_q;
    if (sel_load)                pend_d = arm_fire;
    else if (pend_q && pps_hit)  pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_secs_q  <= '0;
      ld_ticks_q <= '0;
      edge_q     <= TK_EDGE_FALL;
      tps_q      <= TICK_W'(DEF_TPS);
      pend_q     <= 1'b0;
    end else begin
      if (sel_secs)  ld_secs_q  <= wr_data[SEC_W-1:0];
      if (sel_ticks) ld_ticks_q <= wr_data[TICK_W-1:0];
      if (sel_flags) edge_q     <= tk_edge_e'(wr_data[0]);
      if (sel_tps)   tps_q      <= wr_data[TICK_W-1:0];
      pend_q <= pend_d;
    end
  end

  always_comb begin
    ld_secs  = ld_secs_q;
    ld_ticks = ld_ticks_q;
    edge_sel = edge_q;
    pending  = pend_q;
    tps_last = (tps_q == '0) ? '0 : tps_q - TICK_W'(1);
    apply    = imm_fire | (pend_q & pps_hit & ~sel_load);
  end

endmodule

// File: rtl/tk_count.sv
module tk_count #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [SEC_W-1:0]  ld_secs,
  input  logic [TICK_W-1:0] ld_ticks,
  input  logic [TICK_W-1:0] tps_last,
  output logic [SEC_W-1:0]  secs,
  output logic [TICK_W-1:0] ticks
);

  logic [SEC_W-1:0]  secs_q, secs_d;
  logic [TICK_W-1:0] ticks_q, ticks_d;

  always_comb begin
    secs_d  = secs_q;
    ticks_d = ticks_q;
    if (apply) begin
      secs_d  = ld_secs;
      ticks_d = ld_ticks;
    end else if (ticks_q >= tps_last) begin
      ticks_d = '0;
      secs_d  = secs_q + SEC_W'(1);
    end else begin
      ticks_d = ticks_q + TICK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q  <= '0;
      ticks_q <= '0;
    end else begin
      secs_q  <= secs_d;
      ticks_q <= ticks_d;
    end
  end

  assign secs  = secs_q;
  assign ticks = ticks_q;

endmodule

// File: rtl/tk_readback.sv
module tk_readback #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [SEC_W-1:0]  secs,
  input  logic [TICK_W-1:0] ticks,
  output logic [TICK_W-1:0] shadow,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] data_q, data_d;
  logic [TICK_W-1:0] shadow_q;
  logic              shadow_en;

  always_comb begin
    shadow_en = rd_en & ~rd_sel;
    data_d    = rd_sel ? DATA_W'(shadow_q) : DATA_W'(secs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (rd_en)     data_q   <= data_d;
      if (shadow_en) shadow_q <= ticks;
    end
  end

  assign rd_data = data_q;
  assign shadow  = shadow_q;

endmodule

// File: rtl/sectick_timekeeper.sv
module sectick_timekeeper
  import tk_pkg::*;
#(
  parameter int unsigned IDX_W       = 3,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned TICK_W      = 32,
  parameter int unsigned DEF_TPS     = 100000000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pps_in,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data
);

  logic              rst_sync_n;
  logic              pps_hit;
  tk_edge_e          edge_sel;
  logic [SEC_W-1:0]  ld_secs;
  logic [TICK_W-1:0] ld_ticks;
  logic [TICK_W-1:0] tps_last;
  logic              pending;
  logic              apply;
  logic [SEC_W-1:0]  secs;
  logic [TICK_W-1:0] ticks;
  logic [TICK_W-1:0] shadow;

  tk_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tk_pps_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pps_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pps_in   (pps_in),
    .edge_sel (edge_sel),
    .pps_hit  (pps_hit)
  );

  tk_ctrl #(
    .IDX_W   (IDX_W),
    .DATA_W  (DATA_W),
    .SEC_W   (SEC_W),
    .TICK_W  (TICK_W),
    .DEF_TPS (DEF_TPS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .pps_hit  (pps_hit),
    .ld_secs  (ld_secs),
    .ld_ticks (ld_ticks),
    .tps_last (tps_last),
    .edge_sel (edge_sel),
    .pending  (pending),
    .apply    (apply)
  );

  tk_count #(.SEC_W(SEC_W), .TICK_W(TICK_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .apply    (apply),
    .ld_secs  (ld_secs),
    .ld_ticks (ld_ticks),
    .tps_last (tps_last),
    .secs     (secs),
    .ticks    (ticks)
  );

  tk_readback #(.DATA_W(DATA_W), .SEC_W(SEC_W), .TICK_W(TICK_W)) u_readback (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .secs    (secs),
    .ticks   (ticks),
    .shadow  (shadow),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/tk_checker.sv
module tk_checker
  import tk_pkg::*;
#(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned TICK_W = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic              rd_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              pps_hit,
  input logic              pending,
  input logic              apply,
  input logic [SEC_W-1:0]  ld_secs,
  input logic [TICK_W-1:0] ld_ticks,
  input logic [TICK_W-1:0] tps_last,
  input logic [SEC_W-1:0]  secs,
  input logic [TICK_W-1:0] ticks,
  input logic [TICK_W-1:0] shadow
);

  logic load_wr;
  assign load_wr = wr_en && (wr_idx == IDX_W'(TK_IDX_LOAD));

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!apply && ticks < tps_last) |=> (ticks == TICK_W'($past(ticks) + TICK_W'(1))) && (secs == $past(secs))); // R3

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!apply && ticks >= tps_last) |=> (ticks == '0) && (secs == SEC_W'($past(secs) + SEC_W'(1)))); // R4

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    apply |=> (secs == $past(ld_secs)) && (ticks == $past(ld_ticks))); // R9

  AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_wr && wr_data[0]) |=> (secs == $past(ld_secs)) && (ticks == $past(ld_ticks)) && !pending); // R5

  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_wr && !wr_data[0]) |=> pending); // R6

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pending && pps_hit && !load_wr) |=> !pending); // R8

  AST_NO_STRAY_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pending && !load_wr) |-> !apply); // R8

  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && !rd_sel) |=> (shadow == $past(ticks)) && (rd_data == DATA_W'($past(secs)))); // R10

endmodule

bind sectick_timekeeper tk_checker #(
  .IDX_W  (IDX_W),
  .DATA_W (DATA_W),
  .SEC_W  (SEC_W),
  .TICK_W (TICK_W)
) u_tk_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_sel     (rd_sel),
  .rd_data    (rd_data),
  .pps_hit    (pps_hit),
  .pending    (pending),
  .apply      (apply),
  .ld_secs    (ld_secs),
  .ld_ticks   (ld_ticks),
  .tps_last   (tps_last),
  .secs       (secs),
  .ticks      (ticks),
  .shadow     (shadow)
);

// File: tb/test_sectick_timekeeper.sv
`timescale 1ns/1ps
module test_sectick_timekeeper;

  localparam int unsigned IDX_W   = 3;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned DEF_TPS = 1000;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              pps_in;
  logic              rd_en;
  logic              rd_sel;
  logic [DATA_W-1:0] rd_data;

  int     n_checks;
  int     n_errors;
  longint cyc;
  bit     done;

  // Model of the last load: values (m_s, m_t) hold right after edge m_c
  longint m_s, m_t, m_c, m_tps;

  sectick_timekeeper #(
    .IDX_W   (IDX_W),
    .DATA_W  (DATA_W),
    .DEF_TPS (DEF_TPS)
  ) i_sectick_timekeeper (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .pps_in  (pps_in),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input longint data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_idx  = IDX_W'(idx);
    wr_data = DATA_W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Reads seconds then the ticks snapshot; compares with the model
  task automatic read_check(input string tag);
    longint e, n, s_rd, t_rd;
    @(negedge clk);
    rd_en  = 1'b1;
    rd_sel = 1'b0;
    @(negedge clk);
    e      = cyc;
    s_rd   = longint'(rd_data);
    rd_sel = 1'b1;
    @(negedge clk);
    t_rd   = longint'(rd_data);
    rd_en  = 1'b0;
    rd_sel = 1'b0;
    n = m_t + (e - 1 - m_c);
    chk({tag, " secs"},  s_rd, m_s + n / m_tps);
    chk({tag, " ticks"}, t_rd, n % m_tps);
  endtask

  task automatic imm_load(input longint s, input longint t);
    wr(0, s);
    wr(1, t);
    wr(3, 1);
    m_s = s;
    m_t = t;
    m_c = cyc;
  endtask

  task automatic pps_drive(input logic v, output longint k);
    @(negedge clk);
    pps_in = v;
    k = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    longint k;
    n_checks = 0;
    n_errors = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    wr_idx   = '0;
    wr_data  = '0;
    pps_in   = 1'b0;
    rd_en    = 1'b0;
    rd_sel   = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 rd_data in reset", longint'(rd_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 rd_data after reset", longint'(rd_data), 0);
    // R2: seconds still 0 well before DEF_TPS ticks elapse
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R2 secs after reset", longint'(rd_data), 0);

    // R1 R3 R4 R5 R9: sweep limits 0..5 and every legal start tick
    for (int tps = 0; tps <= 5; tps++) begin
      for (int t0 = 0; t0 < ((tps == 0) ? 1 : tps); t0++) begin
        wr(4, tps);
        m_tps = (tps == 0) ? 1 : tps;
        imm_load(1000 + 10 * tps, t0);
        for (int g = 0; g < 3; g++) begin
          read_check($sformatf("R3 R4 R5 tps=%0d t0=%0d g=%0d", tps, t0, g));
          repeat (g) @(negedge clk);
        end
      end
    end

    // R9: loading while ticks sit on the last value takes the load, not a wrap
    wr(4, 3);
    m_tps = 3;
    imm_load(77, 2);
    read_check("R9 load at wrap");

    // R11: staging and flags writes leave the running time alone
    wr(4, 7);
    m_tps = 7;
    imm_load(50, 0);
    wr(0, 12345);
    wr(1, 4);
    wr(2, 1);
    read_check("R11 staging writes");

    // R6 R7: rising edge selected, armed load waits for the pulse
    wr(0, 900);
    wr(1, 3);
    wr(3, 0);
    repeat (10) @(negedge clk);
    read_check("R6 armed no pulse");
    pps_drive(1'b1, k);
    m_s = 900;
    m_t = 3;
    m_c = k + 3;
    repeat (5) @(negedge clk);
    read_check("R6 rising load");
    // R8: later edges after the load do nothing
    pps_drive(1'b0, k);
    repeat (6) @(negedge clk);
    pps_drive(1'b1, k);
    repeat (6) @(negedge clk);
    read_check("R8 single load");

    // R7: falling edge selected, rising edge ignored
    pps_drive(1'b0, k);
    repeat (6) @(negedge clk);
    wr(2, 0);
    wr(0, 400);
    wr(1, 1);
    wr(3, 0);
    pps_drive(1'b1, k);
    repeat (6) @(negedge clk);
    read_check("R7 rising ignored");
    pps_drive(1'b0, k);
    m_s = 400;
    m_t = 1;
    m_c = k + 3;
    repeat (5) @(negedge clk);
    read_check("R7 falling load");

    // R5: an immediate load cancels a pending arm
    wr(0, 600);
    wr(1, 2);
    wr(3, 0);
    imm_load(700, 5);
    pps_drive(1'b1, k);
    repeat (4) @(negedge clk);
    pps_drive(1'b0, k);
    repeat (6) @(negedge clk);
    read_check("R5 cancel arm");

    // R10: snapshot holds while time moves on
    @(negedge clk);
    rd_en  = 1'b1;
    rd_sel = 1'b0;
    @(negedge clk);
    k = cyc;
    rd_en = 1'b0;
    repeat (9) @(negedge clk);
    rd_en  = 1'b1;
    rd_sel = 1'b1;
    @(negedge clk);
    rd_en  = 1'b0;
    rd_sel = 1'b0;
    chk("R10 snapshot held", longint'(rd_data), (m_t + (k - 1 - m_c)) % m_tps);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule